// File: doc/BRIEF.md
# Floating-Point Compare and Exception Status Unit

This unit holds the floating-point status word of a processor and keeps it current. It classifies two single-precision operands as less, equal, greater or unordered and stores the 2-bit outcome in one of four condition fields. It also takes the five raw IEEE exception flags reported by an external arithmetic pipeline and folds them into the status word. An unmasked exception records the IEEE trap type and raises a one-clock trap request.

Both operations share one 38-bit status register. Software can overwrite the whole register through a load port, which is also the only way to change the trap-enable field. Every update lands on the clock edge that samples the strobe, so the new status and any trap pulse are visible one cycle after the strobe.

Status word layout: current exceptions [4:0], accrued exceptions [9:5], condition field 0 [11:10], trap type [16:14], trap enables [27:23], condition fields 1, 2 and 3 at [33:32], [35:34] and [37:36]. In each 5-bit exception group, bit 4 is invalid, 3 is overflow, 2 is underflow, 1 is divide-by-zero and 0 is inexact. The IEEE trap type code is 3'b001.

Top module: `fpsu_top`

## Requirements
- R1: After synchronous reset, status is all zeros and trap_req is low.
- R2: A compare strobe writes a 2-bit code into the field picked by cmp_sel (0→[11:10], 1→[33:32], 2→[35:34], 3→[37:36]). The codes are equal=00, less=01, greater=10, unordered=11. Other condition fields are left unchanged.
- R3: An operand whose exponent is all ones and whose fraction is non-zero is a NaN and gives unordered. Infinities order normally. +0 and −0 compare equal. Ordering follows the real values, negative numbers included.
- R4: An unordered quiet compare (cmp_signal=0) with the invalid enable (bit 27) clear writes 11, sets accrued invalid (bit 9), leaves current exceptions and trap type alone, and raises no trap.
- R5: An unordered compare with cmp_signal=1, or with bit 27 set, writes 11, sets current invalid (bit 4), sets the trap type to 001 and raises a trap.
- R6: An exception strobe with non-zero flags replaces the current exceptions with the flags. If any flag has its enable set, the trap type becomes 001, a trap is raised and the accrued field is kept. Otherwise the flags are ORed into the accrued field. Zero flags change nothing.
- R7: trap_req is high only in the cycle after a trapping event and low in every other cycle.
- R8: A load writes ld_data to the whole register and overrides any strobe in the same cycle. With no strobe and no load, status holds.
- R9: When compare and exception strobes come in the same cycle, only the compare is applied.
- R10: The trap-enable field changes only through a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load whole status word |
| ld_data | input | 38 | Value to load |
| cmp_vld | input | 1 | Compare strobe |
| cmp_signal | input | 1 | Signaling compare: unordered always traps |
| cmp_sel | input | 2 | Condition field select |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| exc_vld | input | 1 | Exception flag strobe |
| exc_flags | input | 5 | Raw IEEE flags (invalid, overflow, underflow, div-zero, inexact) |
| status | output | 38 | Registered status word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Every result is due one clock after the strobe that causes it: the condition field, the exception fields, the trap type and the trap pulse all come from the same register stage. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge from the same inputs. It then compares both outputs just after that edge, so each check falls in exactly the cycle the result is due. Because the comparison runs every cycle, trap_req is also checked to be low in every cycle that should not carry a pulse.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int EXC_W    = 5;
  localparam int ST_W     = 38;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = CEXC_LSB + 5;
  localparam int TEM_LSB  = CEXC_LSB + 23;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int CC_BASE  = 10;
  localparam int NUM_CC   = 4;
  localparam int CC_W     = 2;
  localparam int SEL_W    = $clog2(NUM_CC);
  localparam int INV_BIT  = 4;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  // Condition field k sits at CC_BASE, then CC_BASE+22, +24, +26.
  function automatic int cc_lsb(input int k);
    return (k == 0) ? CC_BASE : CC_BASE + 20 + 2 * k;
  endfunction
endpackage

// File: rtl/fpsu_classify.sv
module fpsu_classify
  import fpsu_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  output rel_e                  rel
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic             sa, sb, nan_a, nan_b, a_below;
  logic [W-2:0]     mag_a, mag_b;

  assign sa    = a[W-1];
  assign sb    = b[W-1];
  assign mag_a = a[W-2:0];
  assign mag_b = b[W-2:0];
  assign nan_a = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
  assign nan_b = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);
  assign a_below = mag_a < mag_b;

  always_comb begin
    if (nan_a || nan_b)
      rel = REL_UN;
    else if ((mag_a == '0) && (mag_b == '0))
      rel = REL_EQ;
    else if (sa != sb)
      rel = sa ? REL_LT : REL_GT;
    else if (mag_a == mag_b)
      rel = REL_EQ;
    else
      rel = (a_below ^ sa) ? REL_LT : REL_GT;
  end
endmodule

// File: rtl/fpsu_exc_eval.sv
module fpsu_exc_eval
  import fpsu_pkg::*;
(
  input  logic [EXC_W-1:0] cur,
  input  logic [EXC_W-1:0] en,
  input  logic [EXC_W-1:0] acc,
  output logic             trap,
  output logic [EXC_W-1:0] acc_next
);
  assign trap     = |(cur & en);
  assign acc_next = trap ? acc : (acc | cur);
endmodule

// File: rtl/fpsu_top.sv
module fpsu_top
  import fpsu_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_en,
  input  logic [ST_W-1:0]        ld_data,
  input  logic                   cmp_vld,
  input  logic                   cmp_signal,
  input  logic [SEL_W-1:0]       cmp_sel,
  input  logic [EXP_W+FRAC_W:0]  op_a,
  input  logic [EXP_W+FRAC_W:0]  op_b,
  input  logic                   exc_vld,
  input  logic [EXC_W-1:0]       exc_flags,
  output logic [ST_W-1:0]        status,
  output logic                   trap_req
);
  logic [ST_W-1:0]  st_q, st_d;
  logic             trap_q, trap_d;
  rel_e             rel;
  logic             exc_trap;
  logic [EXC_W-1:0] acc_next;
  logic [CC_W-1:0]  cc_next [NUM_CC];
  logic [EXC_W-1:0] tem_cur, aexc_cur;

  assign tem_cur  = st_q[TEM_LSB +: EXC_W];
  assign aexc_cur = st_q[AEXC_LSB +: EXC_W];

  fpsu_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .a   (op_a),
    .b   (op_b),
    .rel (rel)
  );

  fpsu_exc_eval u_exc (
    .cur      (exc_flags),
    .en       (tem_cur),
    .acc      (aexc_cur),
    .trap     (exc_trap),
    .acc_next (acc_next)
  );

  // Each condition field either takes the new code or keeps its value.
  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    assign cc_next[g] = (cmp_sel == SEL_W'(g)) ? CC_W'(rel)
                                                 : st_q[cc_lsb(g) +: CC_W];
  end

  always_comb begin
    st_d   = st_q;
    trap_d = 1'b0;
    if (ld_en) begin
      st_d = ld_data;
    end else if (cmp_vld) begin
      for (int k = 0; k < NUM_CC; k++)
        st_d[cc_lsb(k) +: CC_W] = cc_next[k];
      if (rel == REL_UN) begin
        if (cmp_signal || tem_cur[INV_BIT]) begin
          st_d[CEXC_LSB + INV_BIT]  = 1'b1;
          st_d[FTT_LSB +: FTT_W]    = FTT_IEEE;
          trap_d                    = 1'b1;
        end else begin
          st_d[AEXC_LSB + INV_BIT]  = 1'b1;
        end
      end
    end else if (exc_vld && (exc_flags != '0)) begin
      st_d[CEXC_LSB +: EXC_W] = exc_flags;
      st_d[AEXC_LSB +: EXC_W] = acc_next;
      if (exc_trap) begin
        st_d[FTT_LSB +: FTT_W] = FTT_IEEE;
        trap_d                 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      trap_q <= trap_d;
    end
  end

  assign status   = st_q;
  assign trap_req = trap_q;
endmodule

// File: rtl/fpsu_chk.sv
module fpsu_chk
  import fpsu_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            ld_en,
  input logic            cmp_vld,
  input logic            exc_vld,
  input logic [ST_W-1:0] status,
  input logic            trap_req
);
  assert_trap_cause_R7: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(!ld_en && (cmp_vld || exc_vld)));

  assert_trap_type_R5: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (status[FTT_LSB +: FTT_W] == FTT_IEEE));

  assert_accrued_grows_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_en) |-> ((status[AEXC_LSB +: EXC_W] & $past(status[AEXC_LSB +: EXC_W]))
                       == $past(status[AEXC_LSB +: EXC_W])));

  assert_enable_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_en) |-> $stable(status[TEM_LSB +: EXC_W]));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!ld_en && !cmp_vld && !exc_vld) |-> ($stable(status) && !trap_req));
endmodule

bind fpsu_top fpsu_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .ld_en    (ld_en),
  .cmp_vld  (cmp_vld),
  .exc_vld  (exc_vld),
  .status   (status),
  .trap_req (trap_req)
);

// File: tb/fpsu_top_tb_top.sv
module fpsu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [37:0] ld_data = '0;
  logic        cmp_vld = 1'b0;
  logic        cmp_signal = 1'b0;
  logic [1:0]  cmp_sel = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        exc_vld = 1'b0;
  logic [4:0]  exc_flags = '0;
  logic [37:0] status;
  logic        trap_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";
  logic [37:0] m_st = '0;
  logic        m_trap = 1'b0;

  always #5 clk = ~clk;

  fpsu_top dut_i (.*);

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic longint okey(logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic int field_pos(int s);
    case (s)
      0: return 10;
      1: return 32;
      2: return 34;
      default: return 36;
    endcase
  endfunction

  // Behavioural next-state model from the requirements.
  task automatic model_step();
    logic [37:0] n = m_st;
    bit t = 0;
    if (ld_en) n = ld_data;
    else if (cmp_vld) begin
      logic [1:0] code;
      if (is_nan(op_a) || is_nan(op_b)) code = 2'b11;
      else if (okey(op_a) < okey(op_b)) code = 2'b01;
      else if (okey(op_a) > okey(op_b)) code = 2'b10;
      else code = 2'b00;
      n[field_pos(cmp_sel) +: 2] = code;
      if (code == 2'b11) begin
        if (cmp_signal || m_st[27]) begin
          n[4] = 1; n[16:14] = 3'd1; t = 1;
        end else n[9] = 1;
      end
    end else if (exc_vld && exc_flags != 0) begin
      n[4:0] = exc_flags;
      if ((exc_flags & m_st[27:23]) != 0) begin
        n[16:14] = 3'd1; t = 1;
      end else n[9:5] = m_st[9:5] | exc_flags;
    end
    m_st = n;
    m_trap = t;
  endtask

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      model_step();
      #1;
      check({tag, " status"}, 64'(status), 64'(m_st));
      check({tag, " trap"},   64'(trap_req), 64'(m_trap));
    end
  end

  task automatic idle();
    @(negedge clk);
    ld_en = 0; cmp_vld = 0; exc_vld = 0;
  endtask

  task automatic do_cmp(logic [31:0] a, logic [31:0] b, logic [1:0] s, logic sig);
    @(negedge clk);
    ld_en = 0; exc_vld = 0;
    cmp_vld = 1; op_a = a; op_b = b; cmp_sel = s; cmp_signal = sig;
  endtask

  task automatic do_exc(logic [4:0] f);
    @(negedge clk);
    ld_en = 0; cmp_vld = 0;
    exc_vld = 1; exc_flags = f;
  endtask

  task automatic do_ld(logic [37:0] v);
    @(negedge clk);
    cmp_vld = 0; exc_vld = 0;
    ld_en = 1; ld_data = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    check("R1 reset status", 64'(status), 64'd0);
    check("R1 reset trap",   64'(trap_req), 64'd0);
    @(negedge clk) rst = 0;

    // R2: codes into each field
    tag = "R2";
    do_cmp(32'h3F800000, 32'h40000000, 2'd0, 0);  // 1 < 2
    do_cmp(32'h40000000, 32'h3F800000, 2'd1, 0);  // 2 > 1
    do_cmp(32'h40400000, 32'h40400000, 2'd2, 0);  // equal
    do_cmp(32'hBF800000, 32'hC0000000, 2'd3, 1);  // -1 > -2
    do_cmp(32'hC0000000, 32'h3F800000, 2'd0, 0);  // -2 < 1
    idle();

    // R3: zeros, infinity, NaN
    tag = "R3";
    do_cmp(32'h00000000, 32'h80000000, 2'd1, 0);
    do_cmp(32'h7F800000, 32'h3F800000, 2'd2, 0);
    do_cmp(32'hFF800000, 32'h7F800000, 2'd3, 0);
    // R4: quiet unordered, enable clear
    tag = "R4";
    do_cmp(32'h7FC00000, 32'h3F800000, 2'd0, 0);
    idle();
    // R5 / R7: signaling unordered traps, then pulse ends
    tag = "R5_R7";
    do_cmp(32'h3F800000, 32'hFF800001, 2'd1, 1);
    idle(); idle();
    // R8: load enables invalid, then quiet unordered traps (R5)
    tag = "R8";
    do_ld(38'h1 << 27);
    tag = "R5";
    do_cmp(32'h7FFFFFFF, 32'h00000000, 2'd2, 0);
    idle();
    // R6: flags with overflow enabled
    tag = "R6";
    do_ld(38'h1 << 26);
    do_exc(5'b00001);
    do_exc(5'b00000);
    do_exc(5'b01000);
    idle();
    do_exc(5'b10110);
    idle();
    // R8: load overrides a compare; R9: compare wins over flags
    tag = "R8";
    @(negedge clk);
    ld_en = 1; ld_data = 38'h0; cmp_vld = 1; op_a = 32'h7FC00000; cmp_signal = 1; exc_vld = 0;
    idle();
    tag = "R9";
    @(negedge clk);
    ld_en = 0; cmp_vld = 1; op_a = 32'h3F800000; op_b = 32'h3F800000; cmp_sel = 0;
    cmp_signal = 0; exc_vld = 1; exc_flags = 5'b11111;
    idle();

    // R10 and general: random traffic
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 19);
      logic [31:0] a = $urandom();
      logic [31:0] b = $urandom();
      if ($urandom_range(0, 3) == 0) a = 32'h7F800000 | ($urandom() & 32'h807FFFFF);
      if ($urandom_range(0, 5) == 0) b = a ^ 32'h80000000;
      @(negedge clk);
      ld_en   = (r == 0);
      ld_data = {$urandom(), $urandom()};
      cmp_vld = (r > 0 && r < 10);
      exc_vld = (r >= 8 && r < 17);
      exc_flags = 5'($urandom());
      op_a = a; op_b = b;
      cmp_sel = 2'($urandom());
      cmp_signal = 1'($urandom());
    end
    idle(); idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule